// File: doc/BRIEF.md
# Multi-Window Programmed I/O Host Adapter

This block is the host-side register interface of a network adapter card. A 16-bit host bus addresses eight word registers. The first word is a write-only command register. Reads of that same word return a status register. The second word is a command port for an external management unit. The other six words form three address/data pairs. Each pair is a window into the 64 KiB buffer RAM that sits outside the block.

Each window takes its access mode from a 2-bit field of the command register. A window can be static, it can step up, or it can step down. It can also be redirected to a small internal parameter store. The command register also drives the board reset line, the channel-attention line to the LAN controller and two general-purpose pins. It selects 8-bit or 16-bit transfers. It holds the masks for the two interrupt sources. Management writes are paced by a busy interlock. A write that arrives during the busy window is dropped and leaves a sticky error flag in the status register.

Host addresses are byte offsets. Bit 0 is ignored. A write takes priority when the read and write enables are high in the same cycle. Registers update on the clock edge that ends the access cycle. Read data is combinational within the access cycle.

Top module: `hostadp_top`

## Requirements
- R1: After reset, the following all read as zero: the command register, all status bits, every window address, and the outputs boardReset, chanAttn, gpOut and irqOut.
- R2: A write to offset 0 loads the command register. From the next cycle until the next command write, the outputs follow its bits: boardReset = bit 0, chanAttn = bit 1, gpOut = bits 4:3.
- R3: A read of offset 0 returns the status word: bit 0 LAN interrupt pending, bit 1 management interrupt pending, bit 2 management busy, bit 3 parameter store busy, bit 4 management overrun. All other bits are 0.
- R4: The address ports of windows 0, 1 and 2 are at offsets 4, 8 and 0xC. Each one is written and read back independently.
- R5: A window in mode 0 (static) accesses the buffer RAM at its address register on every data-port access (offsets 6, 0xA, 0xE). The address does not change.
- R6: A window in mode 1 advances its address after each data-port read or write. The step is 2 when command bit 2 is 1 and 1 when it is 0, wrapping modulo 2^16.
- R7: A window in mode 2 steps its address down by the same amount, also wrapping modulo 2^16.
- R8: When command bit 2 is 1, RAM accesses are 16 bits wide. The low byte sits at the window address and the high byte at the address plus 1, with ramByteEn = 2'b11. When bit 2 is 0, only the low byte is written (ramByteEn = 2'b01), and reads return that byte zero-extended.
- R9: A window in mode 3 accesses a 64-entry byte store indexed by address bits 5:0. It uses bits 7:0 of the written word. Reads return the byte zero-extended. It never issues a RAM write, and its address does not change.
- R10: Each parameter-store write holds status bit 3 high for exactly PARAM_BUSY_CYC cycles.
- R11: A write to offset 2 with bit 0 = 1, made while the management unit is not busy, pulses mgmtWrStrobe in that cycle, with mgmtData = bits 15:8 and mgmtSel = bits 7:1. A write with bit 0 = 0 does nothing.
- R12: An accepted management write holds status bit 2 high for exactly MGMT_BUSY_CYC cycles. A management write made during that time produces no strobe and sets status bit 4. Bit 4 is cleared only by a command write with bit 7 = 1.
- R13: A pulse on lanIrqReq or mgmtIrqReq sets status bit 0 or bit 1. The bit stays set until a command write with bit 7 = 1. If a request and such a clear fall in the same cycle, the bit stays set.
- R14: irqOut = (status bit 0 AND command bit 5) OR (status bit 1 AND command bit 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 4 | Host byte offset (bit 0 ignored) |
| hostWrEn | input | 1 | Host write for this cycle |
| hostRdEn | input | 1 | Host read for this cycle |
| hostWrData | input | 16 | Host write word |
| hostRdData | output | 16 | Host read word (combinational) |
| boardReset | output | 1 | Board reset line (command bit 0) |
| chanAttn | output | 1 | Channel attention to the LAN controller (command bit 1) |
| gpOut | output | 2 | General-purpose pins (command bits 4:3) |
| irqOut | output | 1 | Masked interrupt to the host |
| lanIrqReq | input | 1 | Interrupt request pulse from the LAN controller |
| mgmtIrqReq | input | 1 | Interrupt request pulse from the management unit |
| mgmtWrStrobe | output | 1 | Accepted management write, one cycle |
| mgmtSel | output | 7 | Management register select |
| mgmtData | output | 8 | Management data byte |
| ramAddr | output | 16 | Buffer RAM byte address |
| ramWrEn | output | 1 | Buffer RAM write |
| ramByteEn | output | 2 | Byte lanes for a RAM write |
| ramWrData | output | 16 | Buffer RAM write word |
| ramRdData | input | 16 | Buffer RAM read word (combinational) |

## Verification
Results fall due on two timings.

Same-cycle results are sampled 1 ns after the inputs are driven in the access cycle, before the closing edge. These are read data, the RAM address, byte enables and the management strobe.

Next-cycle results are checked only after the edge that ends the access. These are the command-driven pins, window addresses, pending interrupt bits and irqOut.

The bench drives accesses back to back from one falling edge to the next, so each status read covers exactly one cycle. The busy windows are therefore measured by counting consecutive status reads that show the flag, and that count must equal the configured length exactly.

// File: rtl/hostadp_pkg.sv
package hostadp_pkg;
  // Three windows: the host word map (cmd, mgmt, then addr/data pairs) fills 4 address bits.
  localparam int NUM_WIN = 3;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_INC    = 2'd1,
    MODE_DEC    = 2'd2,
    MODE_PARAM  = 2'd3
  } winMode_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic [NUM_WIN-1:0]   addrHit;
    logic [NUM_WIN-1:0]   dataHit;
    logic                 wrEn;
    logic                 rdEn;
    logic                 wide;
    logic [2*NUM_WIN-1:0] modes;
  } winCtl_t;
endpackage

// File: rtl/hostadp_ctrl.sv
module hostadp_ctrl
  import hostadp_pkg::*;
#(
  parameter int MGMT_BUSY_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  hostAddr,
  input  logic        hostWrEn,
  input  logic        hostRdEn,
  input  logic [15:0] hostWrData,
  input  logic        lanIrqReq,
  input  logic        mgmtIrqReq,
  input  logic        paramBusy,
  output logic [15:0] cmdReg,
  output winCtl_t     winCtl,
  output logic        statusHit,
  output logic [15:0] statusWord,
  output logic        irqOut,
  output logic        mgmtWrStrobe,
  output logic [6:0]  mgmtSel,
  output logic [7:0]  mgmtData,
  output logic        lanPend,
  output logic        mgmtPend,
  output logic        mgmtBusy
);
  localparam int MC_W = $clog2(MGMT_BUSY_CYC + 1);

  logic [2:0]         wordIdx;
  logic               wrAcc, rdAcc;
  logic               cmdWr, intrClr, mgmtTry;
  logic [NUM_WIN-1:0] addrHitV, dataHitV;
  logic [MC_W-1:0]    mgmtCnt;
  logic               overrun;

  assign wordIdx = hostAddr[3:1];
  assign wrAcc   = hostWrEn;
  assign rdAcc   = hostRdEn & ~hostWrEn;
  assign cmdWr   = wrAcc && (wordIdx == 3'd0);
  assign intrClr = cmdWr & hostWrData[7];
  assign mgmtTry = wrAcc && (wordIdx == 3'd1) && hostWrData[0];

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_dec
    assign addrHitV[n] = (wordIdx == 3'(2 + 2 * n));
    assign dataHitV[n] = (wordIdx == 3'(3 + 2 * n));
  end

  always_comb begin
    winCtl.addrHit = addrHitV;
    winCtl.dataHit = dataHitV;
    winCtl.wrEn    = wrAcc;
    winCtl.rdEn    = rdAcc;
    winCtl.wide    = cmdReg[2];
    winCtl.modes   = cmdReg[10 +: 2*NUM_WIN];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg   <= '0;
      lanPend  <= 1'b0;
      mgmtPend <= 1'b0;
      overrun  <= 1'b0;
      mgmtCnt  <= '0;
    end else begin
      if (cmdWr) cmdReg <= hostWrData;
      lanPend  <= lanIrqReq  | (lanPend  & ~intrClr);
      mgmtPend <= mgmtIrqReq | (mgmtPend & ~intrClr);
      overrun  <= (mgmtTry & mgmtBusy) | (overrun & ~intrClr);
      if (mgmtTry && !mgmtBusy) mgmtCnt <= MC_W'(MGMT_BUSY_CYC);
      else if (mgmtCnt != '0)   mgmtCnt <= mgmtCnt - 1'b1;
    end
  end

  assign mgmtBusy     = (mgmtCnt != '0);
  assign mgmtWrStrobe = mgmtTry & ~mgmtBusy;
  assign mgmtSel      = hostWrData[7:1];
  assign mgmtData     = hostWrData[15:8];

  assign statusHit  = (wordIdx == 3'd0);
  assign statusWord = {11'd0, overrun, paramBusy, mgmtBusy, mgmtPend, lanPend};
  assign irqOut     = (lanPend & cmdReg[5]) | (mgmtPend & cmdReg[6]);
endmodule

// File: rtl/hostadp_dpath.sv
module hostadp_dpath
  import hostadp_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int PSTORE_DEPTH   = 64,
  parameter int PARAM_BUSY_CYC = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  winCtl_t                   winCtl,
  input  logic [15:0]               hostWrData,
  input  logic [15:0]               ramRdData,
  output logic [ADDR_W-1:0]         ramAddr,
  output logic                      ramWrEn,
  output logic [1:0]                ramByteEn,
  output logic [15:0]               ramWrData,
  output logic [15:0]               winRdData,
  output logic                      paramBusy,
  output logic [NUM_WIN*ADDR_W-1:0] winAddrFlat
);
  localparam int PS_AW = $clog2(PSTORE_DEPTH);
  localparam int PC_W  = $clog2(PARAM_BUSY_CYC + 1);

  logic [ADDR_W-1:0] winAddr [NUM_WIN];
  logic [ADDR_W-1:0] stepVal, selAddr, addrRd;
  winMode_t          selMode;
  logic              anyAddr, anyData, pstoreWr;
  logic [7:0]        pstore [PSTORE_DEPTH];
  logic [PC_W-1:0]   paramCnt;
  logic [PS_AW-1:0]  psIdx;

  assign stepVal = winCtl.wide ? ADDR_W'(2) : ADDR_W'(1);

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_win
    winMode_t mode;
    logic     access;
    assign mode   = winMode_t'(winCtl.modes[2*n +: 2]);
    assign access = winCtl.dataHit[n] & (winCtl.wrEn | winCtl.rdEn);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        winAddr[n] <= '0;
      end else if (winCtl.addrHit[n] && winCtl.wrEn) begin
        winAddr[n] <= ADDR_W'(hostWrData);
      end else if (access) begin
        case (mode)
          MODE_INC: winAddr[n] <= winAddr[n] + stepVal;
          MODE_DEC: winAddr[n] <= winAddr[n] - stepVal;
          default:  winAddr[n] <= winAddr[n];
        endcase
      end
    end
    assign winAddrFlat[n*ADDR_W +: ADDR_W] = winAddr[n];
  end

  always_comb begin
    selAddr = '0;
    selMode = MODE_STATIC;
    addrRd  = '0;
    for (int n = 0; n < NUM_WIN; n++) begin
      if (winCtl.dataHit[n]) begin
        selAddr = winAddr[n];
        selMode = winMode_t'(winCtl.modes[2*n +: 2]);
      end
      if (winCtl.addrHit[n]) addrRd = winAddr[n];
    end
  end

  assign anyAddr   = |winCtl.addrHit;
  assign anyData   = |winCtl.dataHit;
  assign psIdx     = selAddr[PS_AW-1:0];
  assign pstoreWr  = winCtl.wrEn & anyData & (selMode == MODE_PARAM);

  assign ramAddr   = selAddr;
  assign ramWrEn   = winCtl.wrEn & anyData & (selMode != MODE_PARAM);
  assign ramByteEn = winCtl.wide ? 2'b11 : 2'b01;
  assign ramWrData = winCtl.wide ? hostWrData : {8'd0, hostWrData[7:0]};

  always_comb begin
    if (anyAddr)                   winRdData = 16'(addrRd);
    else if (!anyData)             winRdData = '0;
    else if (selMode == MODE_PARAM) winRdData = {8'd0, pstore[psIdx]};
    else if (winCtl.wide)          winRdData = ramRdData;
    else                           winRdData = {8'd0, ramRdData[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PSTORE_DEPTH; i++) pstore[i] <= '0;
      paramCnt <= '0;
    end else begin
      if (pstoreWr) begin
        pstore[psIdx] <= hostWrData[7:0];
        paramCnt      <= PC_W'(PARAM_BUSY_CYC);
      end else if (paramCnt != '0) begin
        paramCnt <= paramCnt - 1'b1;
      end
    end
  end

  assign paramBusy = (paramCnt != '0);
endmodule

// File: rtl/hostadp_top.sv
module hostadp_top
  import hostadp_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int PSTORE_DEPTH   = 64,
  parameter int PARAM_BUSY_CYC = 4,
  parameter int MGMT_BUSY_CYC  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [15:0]       hostWrData,
  output logic [15:0]       hostRdData,
  output logic              boardReset,
  output logic              chanAttn,
  output logic [1:0]        gpOut,
  output logic              irqOut,
  input  logic              lanIrqReq,
  input  logic              mgmtIrqReq,
  output logic              mgmtWrStrobe,
  output logic [6:0]        mgmtSel,
  output logic [7:0]        mgmtData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramWrEn,
  output logic [1:0]        ramByteEn,
  output logic [15:0]       ramWrData,
  input  logic [15:0]       ramRdData
);
  logic [15:0]               cmdReg, statusWord, winRdData;
  winCtl_t                   winCtl;
  logic                      statusHit, paramBusy;
  logic                      lanPend, mgmtPend, mgmtBusy;
  logic [NUM_WIN*ADDR_W-1:0] winAddrFlat;

  hostadp_ctrl #(.MGMT_BUSY_CYC(MGMT_BUSY_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .lanIrqReq(lanIrqReq),
    .mgmtIrqReq(mgmtIrqReq), .paramBusy(paramBusy), .cmdReg(cmdReg),
    .winCtl(winCtl), .statusHit(statusHit), .statusWord(statusWord),
    .irqOut(irqOut), .mgmtWrStrobe(mgmtWrStrobe), .mgmtSel(mgmtSel),
    .mgmtData(mgmtData), .lanPend(lanPend), .mgmtPend(mgmtPend),
    .mgmtBusy(mgmtBusy)
  );

  hostadp_dpath #(
    .ADDR_W(ADDR_W), .PSTORE_DEPTH(PSTORE_DEPTH), .PARAM_BUSY_CYC(PARAM_BUSY_CYC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .winCtl(winCtl), .hostWrData(hostWrData),
    .ramRdData(ramRdData), .ramAddr(ramAddr), .ramWrEn(ramWrEn),
    .ramByteEn(ramByteEn), .ramWrData(ramWrData), .winRdData(winRdData),
    .paramBusy(paramBusy), .winAddrFlat(winAddrFlat)
  );

  assign hostRdData = statusHit ? statusWord : winRdData;
  assign boardReset = cmdReg[0];
  assign chanAttn   = cmdReg[1];
  assign gpOut      = cmdReg[4:3];
endmodule

// File: rtl/hostadp_chk.sv
module hostadp_chk
  import hostadp_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      hostWrEn,
  input logic                      hostRdEn,
  input logic [2:0]                wordIdx,
  input logic                      wrBit1,
  input logic                      chanAttn,
  input logic                      irqOut,
  input logic                      lanIrqReq,
  input logic                      lanPend,
  input logic                      ramWrEn,
  input logic [1:0]                ramByteEn,
  input logic                      mgmtWrStrobe,
  input logic                      mgmtBusy,
  input logic                      wideBit,
  input logic                      maskLan,
  input logic                      maskMgmt,
  input logic [2*NUM_WIN-1:0]      modeBits,
  input logic [NUM_WIN*ADDR_W-1:0] winAddrFlat
);
  // R2
  cmd_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && wordIdx == 3'd0) |=> (chanAttn == $past(wrBit1)));

  // R13
  lan_pend_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    lanIrqReq |=> lanPend);

  // R14
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (maskLan || maskMgmt));

  // R12
  mgmt_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    mgmtWrStrobe |=> mgmtBusy);

  // R11
  mgmt_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    mgmtWrStrobe |-> !mgmtBusy);

  // R8
  narrow_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ramWrEn && !wideBit) |-> (ramByteEn == 2'b01));

  for (genvar n = 0; n < NUM_WIN; n++) begin : g_static
    // R5
    static_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((hostWrEn || hostRdEn) && wordIdx == 3'(3 + 2 * n) && modeBits[2*n +: 2] == 2'd0)
      |=> $stable(winAddrFlat[n*ADDR_W +: ADDR_W]));
  end
endmodule

bind hostadp_top hostadp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .wordIdx(hostAddr[3:1]), .wrBit1(hostWrData[1]), .chanAttn(chanAttn),
  .irqOut(irqOut), .lanIrqReq(lanIrqReq), .lanPend(lanPend),
  .ramWrEn(ramWrEn), .ramByteEn(ramByteEn), .mgmtWrStrobe(mgmtWrStrobe),
  .mgmtBusy(mgmtBusy), .wideBit(cmdReg[2]), .maskLan(cmdReg[5]),
  .maskMgmt(cmdReg[6]), .modeBits(cmdReg[15:10]), .winAddrFlat(winAddrFlat)
);

// File: tb/tb_hostadp_top.sv
`timescale 1ns/1ps
module tb_hostadp_top;
  localparam int PBUSY = 4;
  localparam int MBUSY = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        boardReset, chanAttn, irqOut;
  logic [1:0]  gpOut;
  logic        lanIrqReq = 1'b0, mgmtIrqReq = 1'b0;
  logic        mgmtWrStrobe;
  logic [6:0]  mgmtSel;
  logic [7:0]  mgmtData;
  logic [15:0] ramAddr, ramWrData, ramRdData;
  logic        ramWrEn;
  logic [1:0]  ramByteEn;

  int total = 0, bad = 0;
  int stbCnt = 0, ramWrCnt = 0;
  logic [6:0] stbSel;
  logic [7:0] stbData;
  logic [7:0] bmem [256];
  logic [7:0] loIdx, hiIdx;

  always #2 clk = ~clk;

  hostadp_top #(.PARAM_BUSY_CYC(PBUSY), .MGMT_BUSY_CYC(MBUSY)) dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .boardReset(boardReset), .chanAttn(chanAttn), .gpOut(gpOut), .irqOut(irqOut),
    .lanIrqReq(lanIrqReq), .mgmtIrqReq(mgmtIrqReq), .mgmtWrStrobe(mgmtWrStrobe),
    .mgmtSel(mgmtSel), .mgmtData(mgmtData), .ramAddr(ramAddr), .ramWrEn(ramWrEn),
    .ramByteEn(ramByteEn), .ramWrData(ramWrData), .ramRdData(ramRdData)
  );

  // Bench RAM model: 256 bytes, aliased on the low address byte.
  assign loIdx = ramAddr[7:0];
  assign hiIdx = ramAddr[7:0] + 8'd1;
  assign ramRdData = {bmem[hiIdx], bmem[loIdx]};

  initial for (int i = 0; i < 256; i++) bmem[i] = 8'hEE;

  always @(posedge clk) begin
    if (rstN && ramWrEn) begin
      ramWrCnt++;
      if (ramByteEn[0]) bmem[loIdx] = ramWrData[7:0];
      if (ramByteEn[1]) bmem[hiIdx] = ramWrData[15:8];
    end
    if (rstN && mgmtWrStrobe) begin
      stbCnt++;
      stbSel  = mgmtSel;
      stbData = mgmtData;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Both tasks start and end on a falling edge.
  task automatic busWrite(input logic [3:0] a, input logic [15:0] d);
    hostAddr = a; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [15:0] d);
    hostAddr = a; hostRdEn = 1'b1;
    #1 d = hostRdData;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic countBusy(input int bitPos, output int n);
    logic [15:0] s;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      busRead(4'h0, s);
      if (s[bitPos]) n++;
      else break;
    end
  endtask

  task automatic pulseIrq(input logic lan, input logic mgmt);
    lanIrqReq = lan; mgmtIrqReq = mgmt;
    @(negedge clk);
    lanIrqReq = 1'b0; mgmtIrqReq = 1'b0;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [15:0] rd, a, dat;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(4'h0, rd);
    check("R1 status", rd, 0);
    check("R1 pins", {boardReset, chanAttn, gpOut, irqOut}, 0);
    for (int w = 0; w < 3; w++) begin
      busRead(4'(4 + 4 * w), rd);
      check("R1 winaddr", rd, 0);
    end

    // R2 pin sweep over command bits 4:0
    for (int v = 0; v < 32; v++) begin
      busWrite(4'h0, 16'(v));
      check("R2 pins", {gpOut, chanAttn, boardReset}, {v[4:3], v[1], v[0]});
    end
    busWrite(4'h0, 16'h0000);
    check("R2 attn low", chanAttn, 0);

    // R4 independent address ports
    busWrite(4'h4, 16'h1111);
    busWrite(4'h8, 16'h2222);
    busWrite(4'hC, 16'h3333);
    busRead(4'h4, rd); check("R4 win0", rd, 16'h1111);
    busRead(4'h8, rd); check("R4 win1", rd, 16'h2222);
    busRead(4'hC, rd); check("R4 win2", rd, 16'h3333);

    // R5 static, R8 wide lanes
    busWrite(4'h0, 16'h0004);
    busWrite(4'h4, 16'h0010);
    busWrite(4'h6, 16'hA55A);
    check("R8 wide lo", bmem[8'h10], 8'h5A);
    check("R8 wide hi", bmem[8'h11], 8'hA5);
    busRead(4'h6, rd); check("R5 wide read", rd, 16'hA55A);
    busRead(4'h4, rd); check("R5 addr held", rd, 16'h0010);
    // R8 narrow lanes
    busWrite(4'h0, 16'h0000);
    busWrite(4'h4, 16'h0020);
    busWrite(4'h6, 16'h1234);
    check("R8 narrow lo", bmem[8'h20], 8'h34);
    check("R8 narrow hi untouched", bmem[8'h21], 8'hEE);
    busRead(4'h6, rd); check("R8 narrow read", rd, 16'h0034);
    busRead(4'h4, rd); check("R5 addr held narrow", rd, 16'h0020);

    // R6 / R7 stepping sweep, all windows, both widths, with wrap
    for (int w = 0; w < 3; w++) begin
      for (int md = 1; md <= 2; md++) begin
        for (int wd = 0; wd < 2; wd++) begin
          logic [15:0] start, stp;
          logic [7:0]  exp [4];
          stp   = (wd == 1) ? 16'd2 : 16'd1;
          start = (md == 1) ? 16'hFFFC : 16'h0003;
          busWrite(4'h0, 16'(md << (10 + 2 * w)) | 16'(wd << 2));
          busWrite(4'(4 + 4 * w), start);
          a = start;
          for (int i = 0; i < 4; i++) begin
            dat = {8'(w * 16 + i * 4 + md), 8'(8'h30 + i + wd * 8)};
            exp[i] = dat[7:0];
            busWrite(4'(6 + 4 * w), dat);
            check(md == 1 ? "R6 wr lo" : "R7 wr lo", bmem[a[7:0]], dat[7:0]);
            if (wd == 1) check("R8 wr hi", bmem[8'(a[7:0] + 8'd1)], dat[15:8]);
            a = (md == 1) ? a + stp : a - stp;
          end
          busRead(4'(4 + 4 * w), rd);
          check(md == 1 ? "R6 final addr" : "R7 final addr", rd, a);
          busWrite(4'(4 + 4 * w), start);
          a = start;
          for (int i = 0; i < 4; i++) begin
            busRead(4'(6 + 4 * w), rd);
            check(md == 1 ? "R6 rd data" : "R7 rd data", rd[7:0], exp[i]);
            a = (md == 1) ? a + stp : a - stp;
          end
          busRead(4'(4 + 4 * w), rd);
          check(md == 1 ? "R6 rd addr" : "R7 rd addr", rd, a);
        end
      end
    end

    // R9 parameter store via window 1
    n = ramWrCnt;
    busWrite(4'h0, 16'h3004);
    for (int i = 0; i < 64; i++) begin
      busWrite(4'h8, 16'(i * 65));
      busWrite(4'hA, 16'hFF00 | 16'(8'(i) ^ 8'h5A));
    end
    busRead(4'h8, rd); check("R9 addr held", rd, 16'(63 * 65));
    for (int i = 0; i < 64; i++) begin
      busWrite(4'h8, 16'(i));
      busRead(4'hA, rd);
      check("R9 store read", rd, {8'h00, 8'(i) ^ 8'h5A});
    end
    check("R9 no ram write", ramWrCnt - n, 0);

    // R10 parameter busy length
    busWrite(4'hA, 16'h0077);
    countBusy(3, n);
    check("R10 param busy cycles", n, PBUSY);
    busRead(4'hA, rd); check("R9 last write", rd, 16'h0077);

    // R11 management packing and strobe
    busWrite(4'h0, 16'h0000);
    n = stbCnt;
    busWrite(4'h2, {8'h9C, 7'h2B, 1'b1});
    check("R11 strobe", stbCnt - n, 1);
    check("R11 sel", stbSel, 7'h2B);
    check("R11 data", stbData, 8'h9C);
    // R12 busy length
    countBusy(2, n);
    check("R12 mgmt busy cycles", n, MBUSY);
    // R11 bit0 clear ignored
    n = stbCnt;
    busWrite(4'h2, 16'h4444);
    busRead(4'h0, rd);
    check("R11 no-write ignored", {stbCnt - n, 32'(rd[2])}, 0);
    // R12 overrun
    n = stbCnt;
    busWrite(4'h2, 16'h1103);
    busWrite(4'h2, 16'h2205);
    check("R12 dropped", stbCnt - n, 1);
    check("R12 kept first", stbSel, 7'h01);
    countBusy(2, n);
    busRead(4'h0, rd); check("R12 overrun sticky", rd[4], 1);
    check("R3 status word", rd, 16'h0010);
    busWrite(4'h0, 16'h0060);
    busRead(4'h0, rd); check("R12 overrun kept w/o bit7", rd[4], 1);
    busWrite(4'h0, 16'h0080);
    busRead(4'h0, rd); check("R12 overrun cleared", rd[4], 0);

    // R13 / R14 sweep over pending and masks
    for (int c = 0; c < 16; c++) begin
      busWrite(4'h0, 16'h0080);
      pulseIrq(c[0], c[1]);
      busWrite(4'h0, 16'(c[2] << 5) | 16'(c[3] << 6));
      check("R14 irq", irqOut, (c[0] & c[2]) | (c[1] & c[3]));
      busRead(4'h0, rd);
      check("R13 pending", rd, {14'd0, c[1], c[0]});
    end
    // R13 set wins over clear
    busWrite(4'h0, 16'h0080);
    lanIrqReq = 1'b1;
    busWrite(4'h0, 16'h00A0);
    lanIrqReq = 1'b0;
    busRead(4'h0, rd); check("R13 set wins", rd[0], 1);
    check("R14 irq set wins", irqOut, 1);
    busWrite(4'h0, 16'h00A0);
    busRead(4'h0, rd); check("R13 cleared", rd, 0);
    check("R14 irq cleared", irqOut, 0);

    finishRun();
  end
endmodule